// File: doc/BRIEF.md
# Delayed Request Queue with Retry Arbitration

This block sits on the target side of a bus bridge and keeps the bookkeeping for delayed transactions, reads and writes that the bridge has taken from an initiator and is still carrying to the far bus. Each presentation of a request by an initiator results in exactly one decision. The decision either tells the initiator to retry or tells it that its completed transaction is now being finished. When a request is new and there is room, it is recorded in a small ring of slots, and the initiator is retried. The initiator must then keep presenting the same request until the far side has answered and that slot has reached the head of the ring.

A decision to retry can have several causes, and the block reports which one applied. The slot may still be settling in, or may be waiting on the far bus. The slot may be answered but queued behind an older one. The ring may be full. Another initiator may already own the same address and command. Lock rules may refuse a write. Finally, the data path may have stalled acceptance for too long. The far side reports each answer by slot number. Payload storage and bus signalling belong to neighbouring blocks.

Top module: `dtq_retry_queue`

## Requirements
- R1: A request that matches no occupied slot, arriving while fewer than DEPTH slots are occupied, is stored at the tail slot ((head + count) mod DEPTH) and retried with reason code 1 (enter). The count rises by one. One cycle later the slot shows as waiting in `wait_mask`.
- R2: A request whose address, command and initiator id all match a slot that is entering or waiting is retried with reason code 2 (pending). `dec_slot` gives that slot.
- R3: `cpl_valid` with `cpl_slot` moves a waiting slot to answered, and the slot's bit then appears in `done_mask` (bit i is slot i). A completion that names a free or already answered slot changes nothing.
- R4: A request that matches an answered slot which is not the head is retried with reason code 3 (order).
- R5: A request that matches the answered head slot gets reason code 0 (complete) with `dec_retry` low. In the same cycle the slot is freed, the head advances by one modulo DEPTH, and the count falls by one.
- R6: A request that matches no slot while all DEPTH slots are occupied is retried with reason code 4 (full), and nothing is stored.
- R7: A request whose address and command match an occupied slot owned by a different initiator id is retried with reason code 5 (duplicate), and nothing is stored.
- R8: A write is retried with reason code 6 (lock) when a lock sequence is crossing and the write is not locked, or when the far bus is held and the write is locked. Reads are never refused for lock reasons.
- R9: While `acc_stall` is held, the request is decided on its (ACC_LIMIT+1)th presented cycle with reason code 7 (timeout), and nothing is stored. When the stall lifts earlier, the request is decided in the first cycle without the stall.
- R10: Priority is timeout, then lock, then the slot-match rules, then full. Each decision appears as a single-cycle `dec_valid` pulse, one cycle after the deciding edge. No decision is taken in a cycle where `dec_valid` is high.
- R11: After reset all slots are free, the count and the head are 0, and `dec_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Initiator presents a request, held until `dec_valid` |
| req_addr | input | 32 | Request address |
| req_cmd | input | 4 | Request command code |
| req_id | input | 2 | Initiator identifier |
| req_write | input | 1 | Request is a write |
| req_locked | input | 1 | Request belongs to a locked sequence |
| acc_stall | input | 1 | Data path cannot accept the request this cycle |
| seq_lock | input | 1 | A locked sequence is crossing the bridge |
| bus_lock | input | 1 | The far bus is held locked |
| cpl_valid | input | 1 | Far side answered a slot |
| cpl_slot | input | 2 | Slot that was answered |
| dec_valid | output | 1 | Decision pulse |
| dec_retry | output | 1 | Decision is a retry |
| dec_reason | output | 3 | Reason code 0..7 |
| dec_slot | output | 2 | Slot allocated or matched |
| q_count | output | 3 | Occupied slots |
| q_full | output | 1 | All slots occupied |
| q_head | output | 2 | Oldest slot index |
| wait_mask | output | 4 | Slots waiting for the far side |
| done_mask | output | 4 | Slots answered, not yet returned |

## Verification
A corrupted slot state would make a repeated request show the wrong reason code in the very next decision. For example, pending could appear where order or complete is correct. Such a fault would also show in `wait_mask` or `done_mask` one cycle after the offending event. A head or count error shows as a wrong tail slot in `dec_slot` on the next allocation, and as a wrong `q_head` after a completion. A timer fault shifts the decision cycle of a stalled request away from ACC_LIMIT+1, and the bench measures that shift in whole cycles.

// File: rtl/dtq_pkg.sv
package dtq_pkg;

    localparam int ADDR_W = 32;
    localparam int CMD_W  = 4;
    localparam int ID_W   = 2;

    typedef enum logic [1:0] {
        SLOT_FREE  = 2'd0,
        SLOT_ENTER = 2'd1,
        SLOT_WAIT  = 2'd2,
        SLOT_DONE  = 2'd3
    } slot_st_e;

    typedef enum logic [2:0] {
        RSN_COMPLETE = 3'd0,
        RSN_ENTER    = 3'd1,
        RSN_PENDING  = 3'd2,
        RSN_ORDER    = 3'd3,
        RSN_FULL     = 3'd4,
        RSN_DUP      = 3'd5,
        RSN_LOCK     = 3'd6,
        RSN_TIMEOUT  = 3'd7
    } reason_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [CMD_W-1:0]  cmd;
        logic [ID_W-1:0]   id;
        logic              locked;
        slot_st_e          st;
    } slot_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [CMD_W-1:0]  cmd;
        logic [ID_W-1:0]   id;
        logic              write;
        logic              locked;
    } req_t;

    // Lock rule: writes only
    function automatic logic lock_refused(req_t r, logic seq_on, logic bus_held);
        return r.write && ((seq_on && !r.locked) || (bus_held && r.locked));
    endfunction

    function automatic logic key_eq(slot_t s, req_t r);
        return (s.st != SLOT_FREE) && (s.addr == r.addr) && (s.cmd == r.cmd);
    endfunction

endpackage

// File: rtl/dtq_match.sv
module dtq_match
    import dtq_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  slot_t            slots [DEPTH],
    input  req_t             req,
    output logic [DEPTH-1:0] own_hit,
    output logic [DEPTH-1:0] foreign_hit
);

    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        logic key_hit;
        assign key_hit        = key_eq(slots[i], req);
        assign own_hit[i]     = key_hit && (slots[i].id == req.id);
        assign foreign_hit[i] = key_hit && (slots[i].id != req.id);
    end

endmodule

// File: rtl/dtq_acc_timer.sv
module dtq_acc_timer #(
    parameter int ACC_LIMIT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic present,
    input  logic hold,
    input  logic fire,
    output logic expired
);

    localparam int CNT_W = $clog2(ACC_LIMIT + 1);

    logic [CNT_W-1:0] tmr_q;

    always_ff @(posedge clk) begin
        if (rst || fire || !present) begin
            tmr_q <= '0;
        end else if (tmr_q != CNT_W'(ACC_LIMIT)) begin
            tmr_q <= tmr_q + CNT_W'(1);
        end
    end

    assign expired = present && hold && (tmr_q == CNT_W'(ACC_LIMIT));

    AST_TMR_BOUND: assert property (@(posedge clk) disable iff (rst)
        tmr_q <= CNT_W'(ACC_LIMIT)); // R9

    AST_TMR_IDLE: assert property (@(posedge clk) disable iff (rst)
        !present |=> tmr_q == '0); // R9

endmodule

// File: rtl/dtq_decide.sv
module dtq_decide
    import dtq_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  req_t             req,
    input  logic             timeout,
    input  logic             seq_lock,
    input  logic             bus_lock,
    input  logic [DEPTH-1:0] own_hit,
    input  logic [DEPTH-1:0] foreign_hit,
    input  slot_st_e         st_vec [DEPTH],
    input  logic [IDX_W-1:0] head,
    input  logic [IDX_W-1:0] tail,
    input  logic             full,
    output reason_e          reason,
    output logic [IDX_W-1:0] slot,
    output logic             alloc,
    output logic             complete
);

    logic [IDX_W-1:0] own_idx;
    logic [IDX_W-1:0] foreign_idx;

    always_comb begin
        own_idx     = '0;
        foreign_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (own_hit[i])     own_idx     = IDX_W'(i);
            if (foreign_hit[i]) foreign_idx = IDX_W'(i);
        end
    end

    always_comb begin
        reason   = RSN_ENTER;
        slot     = tail;
        alloc    = 1'b0;
        complete = 1'b0;
        if (timeout) begin
            reason = RSN_TIMEOUT;
            slot   = '0;
        end else if (lock_refused(req, seq_lock, bus_lock)) begin
            reason = RSN_LOCK;
            slot   = '0;
        end else if (|own_hit) begin
            slot = own_idx;
            if (st_vec[own_idx] == SLOT_DONE) begin
                if (own_idx == head) begin
                    reason   = RSN_COMPLETE;
                    complete = 1'b1;
                end else begin
                    reason = RSN_ORDER;
                end
            end else begin
                reason = RSN_PENDING;
            end
        end else if (|foreign_hit) begin
            reason = RSN_DUP;
            slot   = foreign_idx;
        end else if (full) begin
            reason = RSN_FULL;
            slot   = '0;
        end else begin
            alloc = 1'b1;
        end
    end

endmodule

// File: rtl/dtq_retry_queue.sv
module dtq_retry_queue
    import dtq_pkg::*;
#(
    parameter int DEPTH     = 4,
    parameter int ACC_LIMIT = 16,
    localparam int IDX_W    = $clog2(DEPTH),
    localparam int CNT_W    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [CMD_W-1:0]  req_cmd,
    input  logic [ID_W-1:0]   req_id,
    input  logic              req_write,
    input  logic              req_locked,
    input  logic              acc_stall,
    input  logic              seq_lock,
    input  logic              bus_lock,
    input  logic              cpl_valid,
    input  logic [IDX_W-1:0]  cpl_slot,
    output logic              dec_valid,
    output logic              dec_retry,
    output logic [2:0]        dec_reason,
    output logic [IDX_W-1:0]  dec_slot,
    output logic [CNT_W-1:0]  q_count,
    output logic              q_full,
    output logic [IDX_W-1:0]  q_head,
    output logic [DEPTH-1:0]  wait_mask,
    output logic [DEPTH-1:0]  done_mask
);

    slot_t            slots_q   [DEPTH];
    slot_t            slots_nxt [DEPTH];
    slot_st_e         st_vec    [DEPTH];
    logic [IDX_W-1:0] head_q;
    logic [CNT_W-1:0] count_q;
    logic [IDX_W-1:0] tail;
    logic             full;

    logic             dec_valid_q;
    reason_e          dec_reason_q;
    logic [IDX_W-1:0] dec_slot_q;

    req_t             req;
    logic             present;
    logic             expired;
    logic             decide;
    logic [DEPTH-1:0] own_hit;
    logic [DEPTH-1:0] foreign_hit;
    reason_e          reason;
    logic [IDX_W-1:0] slot_sel;
    logic             alloc;
    logic             complete;

    assign req     = '{addr: req_addr, cmd: req_cmd, id: req_id,
                       write: req_write, locked: req_locked};
    assign full    = (count_q == CNT_W'(DEPTH));
    assign tail    = head_q + count_q[IDX_W-1:0];
    assign present = req_valid && !dec_valid_q;
    assign decide  = present && (!acc_stall || expired);

    for (genvar i = 0; i < DEPTH; i++) begin : g_st
        assign st_vec[i]    = slots_q[i].st;
        assign wait_mask[i] = (slots_q[i].st == SLOT_WAIT);
        assign done_mask[i] = (slots_q[i].st == SLOT_DONE);
    end

    dtq_acc_timer #(.ACC_LIMIT(ACC_LIMIT)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .present (present),
        .hold    (acc_stall),
        .fire    (decide),
        .expired (expired)
    );

    dtq_match #(.DEPTH(DEPTH)) u_match (
        .slots       (slots_q),
        .req         (req),
        .own_hit     (own_hit),
        .foreign_hit (foreign_hit)
    );

    dtq_decide #(.DEPTH(DEPTH)) u_decide (
        .req         (req),
        .timeout     (expired),
        .seq_lock    (seq_lock),
        .bus_lock    (bus_lock),
        .own_hit     (own_hit),
        .foreign_hit (foreign_hit),
        .st_vec      (st_vec),
        .head        (head_q),
        .tail        (tail),
        .full        (full),
        .reason      (reason),
        .slot        (slot_sel),
        .alloc       (alloc),
        .complete    (complete)
    );

    // Per-slot next state
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            slots_nxt[i] = slots_q[i];
            if (decide && alloc && (tail == IDX_W'(i))) begin
                slots_nxt[i] = '{addr: req_addr, cmd: req_cmd, id: req_id,
                                 locked: req_locked, st: SLOT_ENTER};
            end else if (decide && complete && (head_q == IDX_W'(i))) begin
                slots_nxt[i].st = SLOT_FREE;
            end else if (slots_q[i].st == SLOT_ENTER) begin
                slots_nxt[i].st = SLOT_WAIT;
            end else if (slots_q[i].st == SLOT_WAIT && cpl_valid
                         && cpl_slot == IDX_W'(i)) begin
                slots_nxt[i].st = SLOT_DONE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                slots_q[i] <= '{addr: '0, cmd: '0, id: '0, locked: 1'b0, st: SLOT_FREE};
            end
            head_q       <= '0;
            count_q      <= '0;
            dec_valid_q  <= 1'b0;
            dec_reason_q <= RSN_COMPLETE;
            dec_slot_q   <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                slots_q[i] <= slots_nxt[i];
            end
            dec_valid_q <= decide;
            if (decide) begin
                dec_reason_q <= reason;
                dec_slot_q   <= slot_sel;
                if (alloc) begin
                    count_q <= count_q + CNT_W'(1);
                end else if (complete) begin
                    count_q <= count_q - CNT_W'(1);
                    head_q  <= head_q + IDX_W'(1);
                end
            end
        end
    end

    assign dec_valid  = dec_valid_q;
    assign dec_retry  = dec_valid_q && (dec_reason_q != RSN_COMPLETE);
    assign dec_reason = dec_reason_q;
    assign dec_slot   = dec_slot_q;
    assign q_count    = count_q;
    assign q_full     = full;
    assign q_head     = head_q;

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        count_q <= CNT_W'(DEPTH)); // R6

    AST_ENTER_GROWS: assert property (@(posedge clk) disable iff (rst)
        (decide && alloc) |=> count_q == $past(count_q) + CNT_W'(1)); // R1

    AST_COMPLETE_ADVANCES: assert property (@(posedge clk) disable iff (rst)
        (decide && complete) |=> head_q == $past(head_q) + IDX_W'(1)); // R5

    AST_NO_STORE_ON_REFUSE: assert property (@(posedge clk) disable iff (rst)
        (dec_valid_q && dec_reason_q >= RSN_FULL) |-> count_q == $past(count_q)); // R6

    AST_DEC_PULSE: assert property (@(posedge clk) disable iff (rst)
        dec_valid_q |=> !dec_valid_q); // R10

    AST_OWNER_UNIQUE: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> $onehot0(own_hit | foreign_hit)); // R7

endmodule

// File: tb/dtq_retry_queue_bench.sv
module dtq_retry_queue_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic [3:0]  req_cmd = '0;
    logic [1:0]  req_id = '0;
    logic        req_write = 1'b0;
    logic        req_locked = 1'b0;
    logic        acc_stall = 1'b0;
    logic        seq_lock = 1'b0;
    logic        bus_lock = 1'b0;
    logic        cpl_valid = 1'b0;
    logic [1:0]  cpl_slot = '0;
    logic        dec_valid, dec_retry, q_full;
    logic [2:0]  dec_reason, q_count;
    logic [1:0]  dec_slot, q_head;
    logic [3:0]  wait_mask, done_mask;

    int n_chk = 0;
    int n_bad = 0;

    localparam int LIMIT = 16;

    always #10 clk = ~clk;

    dtq_retry_queue u_dtq_retry_queue (
        .clk, .rst, .req_valid, .req_addr, .req_cmd, .req_id, .req_write,
        .req_locked, .acc_stall, .seq_lock, .bus_lock, .cpl_valid, .cpl_slot,
        .dec_valid, .dec_retry, .dec_reason, .dec_slot, .q_count, .q_full,
        .q_head, .wait_mask, .done_mask
    );

    logic [31:0] k_addr [4];
    logic [3:0]  k_cmd  [4];
    logic [1:0]  k_id   [4];
    logic        k_wr   [4];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic present(input logic [31:0] a, input logic [3:0] c, input logic [1:0] id,
                           input logic wr, input logic lk, input int stall,
                           output int rsn, output int slot, output int retry, output int lat);
        @(negedge clk);
        req_addr = a; req_cmd = c; req_id = id; req_write = wr; req_locked = lk;
        req_valid = 1'b1;
        acc_stall = (stall > 0);
        lat = 0;
        while (lat < 100) begin
            @(negedge clk);
            lat++;
            if (dec_valid) break;
            acc_stall = (lat < stall);
        end
        rsn = dec_reason; slot = dec_slot; retry = dec_retry;
        req_valid = 1'b0;
        acc_stall = 1'b0;
    endtask

    task automatic expect_dec(input logic [31:0] a, input logic [3:0] c, input logic [1:0] id,
                              input logic wr, input logic lk, input int stall,
                              input int e_rsn, input int e_slot, input int e_lat, input string tag);
        int rsn, slot, retry, lat;
        present(a, c, id, wr, lk, stall, rsn, slot, retry, lat);
        chk(rsn == e_rsn, {tag, " reason"}, rsn, e_rsn);
        if (e_slot >= 0) chk(slot == e_slot, {tag, " slot"}, slot, e_slot);
        chk(retry == (e_rsn != 0 ? 1 : 0), {tag, " retry"}, retry, (e_rsn != 0 ? 1 : 0));
        chk(lat == e_lat, {tag, " latency"}, lat, e_lat);
    endtask

    task automatic complete_slot(input int s);
        @(negedge clk);
        cpl_valid = 1'b1; cpl_slot = 2'(s);
        @(negedge clk);
        cpl_valid = 1'b0;
    endtask

    task automatic repeat_slot(input int s, input int e_rsn, input string tag);
        expect_dec(k_addr[s], k_cmd[s], k_id[s], k_wr[s], 1'b0, 0, e_rsn, s, 1, tag);
    endtask

    initial begin
        #(200000 * 20);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        int e_rsn, e_lat, s_exp;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk(q_count == 0, "R11 count", q_count, 0);
        chk(q_head == 0, "R11 head", q_head, 0);
        chk(dec_valid == 0, "R11 dec_valid", dec_valid, 0);
        chk(wait_mask == 0 && done_mask == 0, "R11 masks", {wait_mask, done_mask}, 0);

        // R1 fill all slots
        for (int i = 0; i < 4; i++) begin
            k_addr[i] = 32'h1000_0000 + 32'(i * 64);
            k_cmd[i]  = 4'(6 + (i % 2));
            k_id[i]   = 2'(i);
            k_wr[i]   = (i % 2 == 0);
            expect_dec(k_addr[i], k_cmd[i], k_id[i], k_wr[i], 1'b0, 0, 1, i, 1, "R1 enter");
            chk(q_count == i + 1, "R1 count", q_count, i + 1);
        end
        @(negedge clk);
        chk(wait_mask == 4'hF, "R1 wait_mask", wait_mask, 15);
        chk(q_full == 1, "R6 q_full", q_full, 1);

        // R6 full
        expect_dec(32'h2000_0000, 4'h7, 2'd0, 1'b0, 1'b0, 0, 4, 0, 1, "R6 full");
        chk(q_count == 4, "R6 count kept", q_count, 4);

        // R7 duplicate from another id
        expect_dec(k_addr[1], k_cmd[1], 2'd3, 1'b0, 1'b0, 0, 5, 1, 1, "R7 dup");
        chk(q_count == 4, "R7 count kept", q_count, 4);

        // R2 pending repeats
        for (int i = 0; i < 4; i++) repeat_slot(i, 2, "R2 pending");

        // R3 / R4
        complete_slot(2);
        chk(done_mask == 4'b0100, "R3 done_mask", done_mask, 4);
        chk(wait_mask == 4'b1011, "R3 wait_mask", wait_mask, 11);
        repeat_slot(2, 3, "R4 order");

        // R8 lock sweep on full queue (full is the fallback)
        for (int v = 0; v < 16; v++) begin
            logic sl, bl, wr, lk;
            sl = v[0]; bl = v[1]; wr = v[2]; lk = v[3];
            @(negedge clk);
            seq_lock = sl; bus_lock = bl;
            e_rsn = (wr && ((sl && !lk) || (bl && lk))) ? 6 : 4;
            expect_dec(32'h3000_0000 + 32'(v * 4), 4'h3, 2'd1, wr, lk, 0, e_rsn, 0, 1, "R8 lock");
        end
        // R10 lock outranks order on a matching write
        @(negedge clk);
        seq_lock = 1'b1; bus_lock = 1'b0;
        expect_dec(k_addr[2], k_cmd[2], k_id[2], 1'b1, 1'b0, 0, 6, 0, 1, "R10 lock>order");
        // R10 timeout outranks lock
        expect_dec(32'h4000_0000, 4'h3, 2'd1, 1'b1, 1'b0, 20, 7, 0, LIMIT + 1, "R10 timeout>lock");
        @(negedge clk);
        seq_lock = 1'b0;

        // R9 stall sweep
        for (int s = 0; s <= 20; s++) begin
            e_rsn = (s > LIMIT) ? 7 : 4;
            e_lat = (s > LIMIT) ? LIMIT + 1 : s + 1;
            expect_dec(32'h5000_0000 + 32'(s * 4), 4'h2, 2'd2, 1'b0, 1'b0, s, e_rsn, 0, e_lat, "R9 stall");
        end
        chk(q_count == 4, "R9 count kept", q_count, 4);

        // R5 head completion
        complete_slot(0);
        chk(done_mask == 4'b0101, "R3 done slot0", done_mask, 5);
        repeat_slot(0, 0, "R5 complete");
        chk(q_count == 3, "R5 count", q_count, 3);
        chk(q_head == 1, "R5 head", q_head, 1);
        complete_slot(0);
        complete_slot(2);
        chk(done_mask == 4'b0100, "R3 ignored cpl", done_mask, 4);
        chk(wait_mask == 4'b1010, "R3 ignored cpl wait", wait_mask, 10);

        // R1 wrap: tail = 1 + 3 = 0
        k_addr[0] = 32'h6000_0000; k_cmd[0] = 4'hB; k_id[0] = 2'd2; k_wr[0] = 1'b1;
        expect_dec(k_addr[0], k_cmd[0], k_id[0], 1'b1, 1'b0, 0, 1, 0, 1, "R1 wrap enter");

        // R2 head still waiting
        repeat_slot(1, 2, "R2 head waiting");

        // R5 drain in arrival order
        complete_slot(1);
        repeat_slot(1, 0, "R5 drain1");
        repeat_slot(2, 0, "R5 drain2");
        complete_slot(3);
        repeat_slot(3, 0, "R5 drain3");
        complete_slot(0);
        repeat_slot(0, 0, "R5 drain0");
        s_exp = 1;
        chk(q_head == s_exp, "R5 head wrap", q_head, s_exp);
        chk(q_count == 0, "R5 empty", q_count, 0);
        chk(wait_mask == 0 && done_mask == 0, "R5 masks clear", {wait_mask, done_mask}, 0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule